// File: doc/BRIEF.md
# Split-Microword Micro-Sequencer

This block is the front end of a microcoded processor pipeline. It forms the address for a synchronous microcode ROM and holds the instruction register and the step counter of the current opcode routine. It decodes the microword that the ROM returns. Each microword is split. One part names the ALU operation that runs in the current cycle. Another part selects the ALU inputs for the operation that follows. Two further bits say whether the ALU result and the carry are fed back into those next inputs. A single bit marks the word that takes a new opcode.

The ROM's registered output serves as the microinstruction register, which sits between fetch and decode. A word with its opcode-take bit set works as an unconditional branch. In that same cycle, the opcode byte on the memory data bus is steered straight into the ROM address as step 0 of its routine. No prefetched word is thrown away, and no idle cycle appears between routines. During reset the sequencer addresses step 0 of the break opcode, so the first word out of reset belongs to that routine.

Top module: `useq_front`

## Requirements
- R1: While `rst_n` is low (a synchronous, active-low reset), `rom_addr` equals `{BRK_OP, 3'b000}`. `op_take`, `rc_res`, `rc_cy`, `alu_op` and `alu_insel` are 0. After one clock edge in reset, `ir` equals `BRK_OP` and `step` equals 0.
- R2: In the first cycle after reset is released, `ir` is `BRK_OP` and `step` is 0. The decoded outputs come from the ROM word at address `{BRK_OP, 0}`.
- R3: The decoded outputs are taken from the word on `rom_data` in the same cycle. The field layout is: bit 0 is opcode-take (`op_take`), bit 1 is recirculate result (`rc_res`), bit 2 is recirculate carry (`rc_cy`), bits [6:3] are the next ALU input select (`alu_insel`), and bits [10:7] are the current ALU operation (`alu_op`).
- R4: When the take bit is clear, `rom_addr` is `{ir, step+1}` and `step` increments at the next edge.
- R5: When the take bit is set, `rom_addr` is `{mem_data, 3'b000}` in the same cycle. At the next edge `ir` loads `mem_data` and `step` returns to 0.
- R6: In the cycle after a take, `rom_data` already holds the step-0 word of the new opcode. `ir` and `step` match it, so back-to-back routines have no bubble cycle, even when every word is a take.
- R7: At `step` = 7 with the take bit clear, the address wraps to `{ir, 0}`, `step` becomes 0, and `ir` is unchanged.
- R8: `mem_data` is ignored when the take bit is clear. `ir` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_data | input | 8 | Opcode byte from the memory read bus |
| rom_data | input | 11 | Registered output word of the microcode ROM |
| rom_addr | output | 11 | Microcode ROM address, {opcode, step} |
| ir | output | 8 | Instruction register |
| step | output | 3 | Step of the word currently in decode |
| alu_op | output | 4 | ALU operation for the current cycle |
| alu_insel | output | 4 | ALU input select for the next operation |
| rc_res | output | 1 | Feed the ALU result back into the next inputs |
| rc_cy | output | 1 | Feed the ALU carry back into the next inputs |
| op_take | output | 1 | Current word takes a new opcode |

## Verification
The bench builds the block with its default sizes: an 8-bit opcode, a 3-bit step and 4-bit operation and select fields. This makes the 2048-word ROM small enough to fill with a computed pattern. Routine lengths from 1 to 8 words therefore reach both the every-cycle-take case and the full step range. One opcode never sets its take bit, which makes the step wrap observable.

// File: rtl/useq_front.sv
module useq_front #(
  parameter int OPW  = 8,
  parameter int STW  = 3,
  parameter int SELW = 4,
  parameter int AOPW = 4,
  parameter logic [OPW-1:0] BRK_OP = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OPW-1:0]            mem_data,
  input  logic [3+SELW+AOPW-1:0]    rom_data,
  output logic [OPW+STW-1:0]        rom_addr,
  output logic [OPW-1:0]            ir,
  output logic [STW-1:0]            step,
  output logic [AOPW-1:0]           alu_op,
  output logic [SELW-1:0]           alu_insel,
  output logic                      rc_res,
  output logic                      rc_cy,
  output logic                      op_take
);
  localparam int UW    = 3 + SELW + AOPW;
  localparam int F_TK  = 0;
  localparam int F_RR  = 1;
  localparam int F_RC  = 2;
  localparam int F_SEL = 3;
  localparam int F_OP  = 3 + SELW;

  logic [OPW-1:0] ir_q;
  logic [STW-1:0] st_q;
  logic [UW-1:0]  word;
  logic [STW-1:0] st_nx;

  assign word  = rst_n ? rom_data : '0;
  assign st_nx = st_q + 1'b1;

  assign op_take   = word[F_TK];
  assign rc_res    = word[F_RR];
  assign rc_cy     = word[F_RC];
  assign alu_insel = word[F_SEL +: SELW];
  assign alu_op    = word[F_OP  +: AOPW];

  always_comb begin
    if (!rst_n)       rom_addr = {BRK_OP, {STW{1'b0}}};
    else if (op_take) rom_addr = {mem_data, {STW{1'b0}}};
    else              rom_addr = {ir_q, st_nx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q <= BRK_OP;
      st_q <= '0;
    end else if (op_take) begin
      ir_q <= mem_data;
      st_q <= '0;
    end else begin
      st_q <= st_nx;
    end
  end

  assign ir   = ir_q;
  assign step = st_q;

  // R1
  always @(posedge clk)
    if (!rst_n) rst_quiet_chk: assert (!op_take && !rc_res && !rc_cy && alu_op == '0);

  // R4
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_take |=> step == STW'($past(step) + 1'b1));

  // R5
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_take |=> (step == '0 && ir == $past(mem_data)));

  // R8
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_take |=> $stable(ir));

  // R7
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_take && (&step)) |=> step == '0);
endmodule

// File: tb/sim_useq_front.sv
`timescale 1ns/1ps
module sim_useq_front;
  localparam logic [7:0] BRK = 8'h00;
  localparam logic [7:0] NOEND = 8'hFE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mem_data;
  logic [10:0] rom_data;
  logic [10:0] rom_addr;
  logic [7:0]  ir;
  logic [2:0]  step;
  logic [3:0]  alu_op;
  logic [3:0]  alu_insel;
  logic        rc_res, rc_cy, op_take;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_ir;
  logic [2:0] exp_st;
  bit prev_take, first;

  logic [10:0] rom [0:2047];

  always #2 clk = ~clk;

  useq_front u0 (.clk(clk), .rst_n(rst_n), .mem_data(mem_data), .rom_data(rom_data),
    .rom_addr(rom_addr), .ir(ir), .step(step), .alu_op(alu_op), .alu_insel(alu_insel),
    .rc_res(rc_res), .rc_cy(rc_cy), .op_take(op_take));

  always @(posedge clk) rom_data <= rom[rom_addr];

  function automatic int rlen(input logic [7:0] op);
    if (op == NOEND) return 9;
    return 1 + ((int'(op) * 5 + 3) % 8);
  endfunction

  function automatic logic [10:0] rom_word(input logic [10:0] a);
    int body;
    body = (int'(a) * 29 + 7) ^ (int'(a) >> 2);
    return {body[9:0], (int'(a[2:0]) == rlen(a[10:3]) - 1)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [7:0] md);
    logic [10:0] w;
    logic [10:0] ea;
    mem_data = md;
    #1;
    w = rom_word({exp_ir, exp_st});
    chk({alu_op, alu_insel, rc_cy, rc_res, op_take} == w,
        first ? "R2" : (prev_take ? "R6" : "R3"),
        {alu_op, alu_insel, rc_cy, rc_res, op_take}, w);
    chk(ir == exp_ir && step == exp_st,
        first ? "R2" : (prev_take ? "R6" : (exp_st == 3'd0 ? "R7" : "R8")),
        {ir, step}, {exp_ir, exp_st});
    if (w[0]) begin
      ea = {md, 3'b000};
      chk(rom_addr == ea, "R5", rom_addr, ea);
    end else begin
      ea = {exp_ir, 3'(exp_st + 3'd1)};
      chk(rom_addr == ea, (exp_st == 3'd7) ? "R7" : "R4", rom_addr, ea);
    end
    first = 1'b0;
    prev_take = w[0];
    if (w[0]) begin exp_ir = md; exp_st = 3'd0; end
    else exp_st = exp_st + 3'd1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] rnd_op();
    logic [7:0] v;
    v = 8'($urandom);
    if (v == NOEND) v = 8'hFD;
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    mem_data = 8'hA5;
    repeat (3) @(negedge clk);
    #1;
    chk(rom_addr == {BRK, 3'b000}, "R1", rom_addr, {BRK, 3'b000});
    chk({op_take, rc_res, rc_cy, alu_op, alu_insel} == '0, "R1",
        {op_take, rc_res, rc_cy, alu_op, alu_insel}, 0);
    chk(ir == BRK && step == 3'd0, "R1", {ir, step}, {BRK, 3'd0});
    @(negedge clk);
    rst_n = 1'b1;
    exp_ir = BRK; exp_st = 3'd0; prev_take = 1'b0; first = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20251));
    for (int a = 0; a < 2048; a++) rom[a] = rom_word(11'(a));
    do_reset();
    for (int i = 0; i < 40; i++) begin
      logic [7:0] lst [4];
      lst = '{8'h01, 8'h09, 8'h11, 8'h19};
      if (rom_word({exp_ir, exp_st})[0]) run_cycle(lst[i % 4]);
      else run_cycle(rnd_op());
    end
    for (int i = 0; i < 3000; i++) run_cycle(rnd_op());
    while (!rom_word({exp_ir, exp_st})[0]) run_cycle(rnd_op());
    run_cycle(NOEND);
    for (int i = 0; i < 20; i++) run_cycle(rnd_op());
    do_reset();
    for (int i = 0; i < 60; i++) run_cycle(rnd_op());
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule